// File: doc/BRIEF.md
# Ethernet Receive Frame Checker with Dribble-Bit Handling

This block follows a serial Ethernet receive front end that has already recovered a clocked bit stream. While carrier sense is high it watches the preamble, locks onto the start-of-frame delimiter, and packs the frame bits that follow into bytes, least significant bit first. The bytes leave on a plain valid/last byte stream. The first bytes of each frame carry a flag that marks them as the destination address field.

A bit-serial CRC-32 runs over every frame bit, including any stray bits that follow the last whole byte. The value used for the frame check is only saved when a byte completes. Trailing bits that fall short of a byte are therefore left out of both the byte stream and the check. When carrier drops, the block gives a one-cycle end-of-frame status with an FCS error flag and a framing error flag. The framing error flag is raised only when the check fails and the frame also ended part-way through a byte. Frames that fail the check are still delivered in full. A saturating counter records frames that are shorter than the minimum length.

Top module: `eth_rx_fcs_chk`

## Requirements
- R1: While searching, the first 8 bits after carrier rises are ignored. The first pair of consecutive 1 bits whose two bits both lie beyond those 8 ends the delimiter, and the frame starts with the next bit.
- R2: A pair of consecutive 0 bits that lies wholly beyond the first 8 searched bits drops the frame. No byte and no end-of-frame status are produced until carrier goes low, and the search restarts when carrier next rises.
- R3: Frame bits are packed least significant bit first (first bit received = bit 0). Each byte is presented with `byte_vld_o` for one cycle. The final byte of a frame carries `byte_last_o`, which is given in the same cycle as `eof_vld_o`.
- R4: `byte_da_o` is 1 for the first 6 bytes of a frame and 0 for all later bytes.
- R5: 1 to 7 bits left over after the last whole byte are discarded. When 8 extra bits arrive, they form a complete byte that is delivered.
- R6: The CRC (polynomial 0x04C11DB7, preset all ones, shifted MSB first in bit order) advances on every frame bit. Its value is saved only on the eighth bit of each byte. `eof_fcs_err_o` is 1 when the saved value differs from 0xC704DD7B.
- R7: `eof_fram_err_o` is 1 only when `eof_fcs_err_o` is 1 and 1 to 7 leftover bits were seen. With no leftover bits it is 0 even when the check fails.
- R8: Frames that fail the check are delivered byte for byte, the same as good frames.
- R9: A frame whose delimiter was found and which holds fewer than 64 whole bytes at carrier drop adds one to `runt_cnt_o`. The counter is 16 bits wide and saturates. `runt_clr_i` clears it on the next edge.
- R10: `eof_vld_o` is a one-cycle pulse, given one cycle after the first sampled low of carrier during a frame. Both error flags are 0 whenever `eof_vld_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| crs_i | input | 1 | Carrier sense from the front end |
| rx_bit_i | input | 1 | Received serial bit |
| rx_bit_vld_i | input | 1 | Strobe, `rx_bit_i` is valid this cycle |
| runt_clr_i | input | 1 | Synchronous clear of the runt counter |
| byte_vld_o | output | 1 | Byte output valid |
| byte_o | output | 8 | Received byte |
| byte_da_o | output | 1 | Byte belongs to the destination address field |
| byte_last_o | output | 1 | Final byte of the frame |
| eof_vld_o | output | 1 | End-of-frame status valid |
| eof_fcs_err_o | output | 1 | Frame check failed |
| eof_fram_err_o | output | 1 | Framing error |
| runt_cnt_o | output | 16 | Runt frame count |

## Verification
The hardest case to reach is a frame that ends between byte boundaries. For this case the two error flags have to come from the CRC saved at the last whole byte, not from the running value. The stimulus builds frames whose check sequence is computed in the bench and then appends 0 to 8 random trailing bits. Some of these frames are left intact and some have a single payload bit flipped, so that good and bad checks each meet every leftover-bit count. Preambles that carry a 1-1 or 0-0 pair inside the ignored window, and one that has a 0-0 pair beyond it, test the window boundary from both sides.

// File: rtl/eth_rx_pkg.sv
package eth_rx_pkg;
   typedef enum logic [1:0] {
      ST_HUNT = 2'd0,
      ST_DATA = 2'd1,
      ST_DROP = 2'd2
   } rx_state_e;

   localparam int unsigned OCTET_W = 8;
endpackage

// File: rtl/eth_rx_sync.sv
// Preamble watcher: skips a leading window, then finds the 1-1 delimiter
// end or a 0-0 pair that condemns the frame.
module eth_rx_sync #(
   parameter int unsigned IGNORE_BITS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic crs_i,
   input  logic bit_i,
   input  logic bit_vld_i,
   output logic sfd_hit_o,
   output logic data_vld_o,
   output logic frame_end_o
);
   import eth_rx_pkg::*;

   localparam int unsigned CNT_W = $clog2(IGNORE_BITS + 2);
   localparam logic [CNT_W-1:0] ARMED = CNT_W'(IGNORE_BITS + 1);

   if (IGNORE_BITS < 1) begin : g_bad_ignore
      $error("IGNORE_BITS must be at least 1");
   end

   rx_state_e        state_q;
   logic [CNT_W-1:0] seen_q;
   logic             prev_q;
   logic             pre_bit;
   logic             armed;
   logic             drop_hit;

   always_comb begin
      pre_bit     = (state_q == ST_HUNT) && crs_i && bit_vld_i;
      armed       = (seen_q == ARMED);
      sfd_hit_o   = pre_bit && armed && prev_q && bit_i;
      drop_hit    = pre_bit && armed && !prev_q && !bit_i;
      data_vld_o  = (state_q == ST_DATA) && crs_i && bit_vld_i;
      frame_end_o = (state_q == ST_DATA) && !crs_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_HUNT;
         seen_q  <= '0;
         prev_q  <= 1'b0;
      end else if (!crs_i) begin
         state_q <= ST_HUNT;
         seen_q  <= '0;
      end else if (state_q == ST_HUNT && pre_bit) begin
         prev_q <= bit_i;
         if (!armed) seen_q <= seen_q + 1'b1;
         if (drop_hit)     state_q <= ST_DROP;
         else if (sfd_hit_o) state_q <= ST_DATA;
      end
   end
endmodule

// File: rtl/eth_rx_crc.sv
// Bit-serial CRC with a running register and a byte-committed copy.
module eth_rx_crc #(
   parameter int unsigned        CRC_W = 32,
   parameter logic [CRC_W-1:0]   POLY  = 32'h04C11DB7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init_i,
   input  logic             bit_vld_i,
   input  logic             bit_i,
   input  logic             commit_i,
   output logic [CRC_W-1:0] saved_o
);
   if (CRC_W < 8) begin : g_bad_width
      $error("CRC_W must be at least 8");
   end

   logic [CRC_W-1:0] run_q;
   logic [CRC_W-1:0] run_nxt;

   always_comb begin
      run_nxt = {run_q[CRC_W-2:0], 1'b0};
      if (run_q[CRC_W-1] ^ bit_i) run_nxt = run_nxt ^ POLY;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || init_i) begin
         run_q   <= '1;
         saved_o <= '1;
      end else if (bit_vld_i) begin
         run_q <= run_nxt;
         if (commit_i) saved_o <= run_nxt;
      end
   end
endmodule

// File: rtl/eth_rx_deser.sv
// LSB-first byte packer; exposes the in-byte bit position for end handling.
module eth_rx_deser #(
   parameter int unsigned W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 init_i,
   input  logic                 bit_vld_i,
   input  logic                 bit_i,
   output logic                 done_o,
   output logic [W-1:0]         byte_o,
   output logic [$clog2(W)-1:0] pos_o
);
   localparam int unsigned POS_W = $clog2(W);
   localparam logic [POS_W-1:0] LAST_POS = POS_W'(W - 1);

   if ((1 << POS_W) != W || W < 2) begin : g_bad_w
      $error("W must be a power of two of at least 2");
   end

   logic [W-1:0] sr_q;

   always_comb begin
      done_o = bit_vld_i && (pos_o == LAST_POS);
      byte_o = {bit_i, sr_q[W-1:1]};
   end

   always_ff @(posedge clk) begin
      if (!rst_n || init_i) begin
         pos_o <= '0;
         sr_q  <= '0;
      end else if (bit_vld_i) begin
         sr_q  <= {bit_i, sr_q[W-1:1]};
         pos_o <= pos_o + 1'b1;
      end
   end
endmodule

// File: rtl/eth_rx_runt_ctr.sv
// Event counter; SATURATE picks between a sticky top and wrap-around.
module eth_rx_runt_ctr #(
   parameter int unsigned W        = 16,
   parameter bit          SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         inc_i,
   output logic [W-1:0] cnt_o
);
   if (SATURATE) begin : g_sat
      always_ff @(posedge clk) begin
         if (!rst_n || clr_i)            cnt_o <= '0;
         else if (inc_i && cnt_o != '1)  cnt_o <= cnt_o + 1'b1;
      end
   end else begin : g_wrap
      always_ff @(posedge clk) begin
         if (!rst_n || clr_i) cnt_o <= '0;
         else if (inc_i)      cnt_o <= cnt_o + 1'b1;
      end
   end
endmodule

// File: rtl/eth_rx_fcs_chk.sv
module eth_rx_fcs_chk #(
   parameter int unsigned MIN_FRAME_BYTES = 64,
   parameter int unsigned DA_BYTES        = 6,
   parameter int unsigned PRE_IGNORE      = 8,
   parameter int unsigned RUNT_W          = 16,
   parameter logic [31:0] CRC_POLY        = 32'h04C11DB7,
   parameter logic [31:0] CRC_RESIDUE     = 32'hC704DD7B
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              crs_i,
   input  logic              rx_bit_i,
   input  logic              rx_bit_vld_i,
   input  logic              runt_clr_i,
   output logic              byte_vld_o,
   output logic [7:0]        byte_o,
   output logic              byte_da_o,
   output logic              byte_last_o,
   output logic              eof_vld_o,
   output logic              eof_fcs_err_o,
   output logic              eof_fram_err_o,
   output logic [RUNT_W-1:0] runt_cnt_o
);
   import eth_rx_pkg::*;

   localparam int unsigned LEN_MAX = (MIN_FRAME_BYTES > DA_BYTES) ? MIN_FRAME_BYTES : DA_BYTES;
   localparam int unsigned LEN_W   = $clog2(LEN_MAX + 1);
   localparam int unsigned POS_W   = $clog2(OCTET_W);
   localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_FRAME_BYTES);
   localparam logic [LEN_W-1:0] DA_L  = LEN_W'(DA_BYTES);

   if (MIN_FRAME_BYTES < 1 || RUNT_W < 2) begin : g_bad_cfg
      $error("MIN_FRAME_BYTES and RUNT_W out of range");
   end

   logic               sfd_hit, data_vld, frame_end;
   logic               oct_done;
   logic [OCTET_W-1:0] oct_val;
   logic [POS_W-1:0]   oct_pos;
   logic [31:0]        crc_saved;

   logic [OCTET_W-1:0] hold_q;
   logic               hold_da_q;
   logic               hold_vld_q;
   logic [LEN_W-1:0]   len_q;
   logic               is_runt;
   logic               fcs_bad;

   eth_rx_sync #(.IGNORE_BITS(PRE_IGNORE)) u_sync (
      .clk, .rst_n, .crs_i, .bit_i(rx_bit_i), .bit_vld_i(rx_bit_vld_i),
      .sfd_hit_o(sfd_hit), .data_vld_o(data_vld), .frame_end_o(frame_end)
   );

   eth_rx_deser #(.W(OCTET_W)) u_deser (
      .clk, .rst_n, .init_i(sfd_hit), .bit_vld_i(data_vld), .bit_i(rx_bit_i),
      .done_o(oct_done), .byte_o(oct_val), .pos_o(oct_pos)
   );

   eth_rx_crc #(.CRC_W(32), .POLY(CRC_POLY)) u_crc (
      .clk, .rst_n, .init_i(sfd_hit), .bit_vld_i(data_vld), .bit_i(rx_bit_i),
      .commit_i(oct_done), .saved_o(crc_saved)
   );

   assign is_runt = frame_end && (len_q < MIN_L);
   assign fcs_bad = (crc_saved != CRC_RESIDUE);

   eth_rx_runt_ctr #(.W(RUNT_W), .SATURATE(1'b1)) u_runt (
      .clk, .rst_n, .clr_i(runt_clr_i), .inc_i(is_runt), .cnt_o(runt_cnt_o)
   );

   // One byte is held back so the final one can be tagged at carrier drop.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q         <= '0;
         hold_da_q      <= 1'b0;
         hold_vld_q     <= 1'b0;
         len_q          <= '0;
         byte_vld_o     <= 1'b0;
         byte_o         <= '0;
         byte_da_o      <= 1'b0;
         byte_last_o    <= 1'b0;
         eof_vld_o      <= 1'b0;
         eof_fcs_err_o  <= 1'b0;
         eof_fram_err_o <= 1'b0;
      end else begin
         byte_vld_o     <= 1'b0;
         byte_last_o    <= 1'b0;
         eof_vld_o      <= 1'b0;
         eof_fcs_err_o  <= 1'b0;
         eof_fram_err_o <= 1'b0;
         if (sfd_hit) begin
            hold_vld_q <= 1'b0;
            len_q      <= '0;
         end
         if (oct_done) begin
            if (hold_vld_q) begin
               byte_vld_o <= 1'b1;
               byte_o     <= hold_q;
               byte_da_o  <= hold_da_q;
            end
            hold_q     <= oct_val;
            hold_da_q  <= (len_q < DA_L);
            hold_vld_q <= 1'b1;
            if (len_q < LEN_W'(LEN_MAX)) len_q <= len_q + 1'b1;
         end
         if (frame_end) begin
            if (hold_vld_q) begin
               byte_vld_o  <= 1'b1;
               byte_last_o <= 1'b1;
               byte_o      <= hold_q;
               byte_da_o   <= hold_da_q;
            end
            hold_vld_q     <= 1'b0;
            eof_vld_o      <= 1'b1;
            eof_fcs_err_o  <= fcs_bad;
            eof_fram_err_o <= fcs_bad && (oct_pos != '0);
         end
      end
   end
endmodule

// File: rtl/eth_rx_fcs_chk_sva.sv
module eth_rx_fcs_chk_sva #(
   parameter int unsigned RUNT_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              crs_i,
   input logic              rx_bit_vld_i,
   input logic              runt_clr_i,
   input logic              byte_vld_o,
   input logic              byte_last_o,
   input logic              eof_vld_o,
   input logic              eof_fcs_err_o,
   input logic              eof_fram_err_o,
   input logic [RUNT_W-1:0] runt_cnt_o
);
   AST_FRAM_NEEDS_FCS: assert property (@(posedge clk) disable iff (!rst_n)
      eof_fram_err_o |-> eof_fcs_err_o); // R7
   AST_FLAGS_ONLY_AT_EOF: assert property (@(posedge clk) disable iff (!rst_n)
      !eof_vld_o |-> (!eof_fcs_err_o && !eof_fram_err_o)); // R10
   AST_EOF_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      eof_vld_o |=> !eof_vld_o); // R10
   AST_EOF_AFTER_CRS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      eof_vld_o |-> !$past(crs_i)); // R10
   AST_LAST_WITH_EOF: assert property (@(posedge clk) disable iff (!rst_n)
      byte_last_o |-> (byte_vld_o && eof_vld_o)); // R3
   AST_MID_BYTE_FROM_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld_o && !byte_last_o) |-> ($past(crs_i) && $past(rx_bit_vld_i))); // R3
   AST_RUNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      runt_clr_i |=> (runt_cnt_o == '0)); // R9
   AST_RUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!runt_clr_i && runt_cnt_o != '1) |=>
      (runt_cnt_o == $past(runt_cnt_o) || runt_cnt_o == RUNT_W'($past(runt_cnt_o) + 1'b1))); // R9
   AST_RUNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
      (!runt_clr_i && runt_cnt_o == '1) |=> (runt_cnt_o == '1)); // R9
endmodule

bind eth_rx_fcs_chk eth_rx_fcs_chk_sva #(.RUNT_W(RUNT_W)) u_sva (
   .clk(clk), .rst_n(rst_n), .crs_i(crs_i), .rx_bit_vld_i(rx_bit_vld_i),
   .runt_clr_i(runt_clr_i), .byte_vld_o(byte_vld_o), .byte_last_o(byte_last_o),
   .eof_vld_o(eof_vld_o), .eof_fcs_err_o(eof_fcs_err_o),
   .eof_fram_err_o(eof_fram_err_o), .runt_cnt_o(runt_cnt_o)
);

// File: tb/eth_rx_fcs_chk_tb.sv
module eth_rx_fcs_chk_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        crs_i = 1'b0;
   logic        rx_bit_i = 1'b0;
   logic        rx_bit_vld_i = 1'b0;
   logic        runt_clr_i = 1'b0;
   logic        byte_vld_o, byte_da_o, byte_last_o;
   logic [7:0]  byte_o;
   logic        eof_vld_o, eof_fcs_err_o, eof_fram_err_o;
   logic [15:0] runt_cnt_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;

   eth_rx_fcs_chk u_dut (
      .clk, .rst_n, .crs_i, .rx_bit_i, .rx_bit_vld_i, .runt_clr_i,
      .byte_vld_o, .byte_o, .byte_da_o, .byte_last_o,
      .eof_vld_o, .eof_fcs_err_o, .eof_fram_err_o, .runt_cnt_o
   );

   // captured output
   logic [7:0] cap_b [0:255];
   logic       cap_da [0:255];
   logic       cap_last [0:255];
   int         ncap = 0;
   int         neof = 0;
   logic       got_fcs, got_fram;

   always @(negedge clk) begin
      if (rst_n) begin
         if (byte_vld_o && ncap < 256) begin
            cap_b[ncap] = byte_o;
            cap_da[ncap] = byte_da_o;
            cap_last[ncap] = byte_last_o;
            ncap++;
         end
         if (eof_vld_o) begin
            neof++;
            got_fcs = eof_fcs_err_o;
            got_fram = eof_fram_err_o;
         end
      end
   end

   function automatic logic [31:0] crc_bit(logic [31:0] c, logic b);
      logic fb;
      fb = c[31] ^ b;
      c = {c[30:0], 1'b0};
      if (fb) c = c ^ 32'h04C11DB7;
      return c;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic put_bit(input logic b);
      @(negedge clk);
      crs_i = 1'b1;
      rx_bit_i = b;
      rx_bit_vld_i = 1'b1;
      @(negedge clk);
      rx_bit_vld_i = 1'b0;
      if ($urandom % 3 == 0) @(negedge clk);
   endtask

   logic tx [0:2047];

   // kind 0 normal preamble, 1 junk pairs inside the ignored window, 2 dropped
   task automatic run_frame(input int nbytes, input int ndrib, input bit corrupt, input int kind);
      int nbits;
      int nfull;
      int drib;
      logic [31:0] c;
      logic [31:0] f;
      logic [15:0] runt_before;
      int bad;
      int bad_da;
      int bad_last;
      logic [7:0] eb;
      bit exp_fcs;
      nbits = 0;
      c = 32'hFFFF_FFFF;
      for (int i = 0; i < nbytes; i++) begin
         eb = 8'($urandom);
         for (int k = 0; k < 8; k++) begin
            tx[nbits] = eb[k];
            c = crc_bit(c, eb[k]);
            nbits++;
         end
      end
      f = ~c;
      for (int k = 31; k >= 0; k--) begin
         tx[nbits] = f[k];
         nbits++;
      end
      if (corrupt) begin
         int p;
         p = (nbytes > 0) ? int'($urandom % (nbytes * 8)) : 3;
         tx[p] = ~tx[p];
      end
      for (int k = 0; k < ndrib; k++) begin
         tx[nbits] = 1'($urandom);
         nbits++;
      end
      nfull = nbits / 8;
      drib  = nbits % 8;
      c = 32'hFFFF_FFFF;
      for (int i = 0; i < nfull * 8; i++) c = crc_bit(c, tx[i]);
      exp_fcs = (c != 32'hC704DD7B);

      ncap = 0;
      neof = 0;
      runt_before = runt_cnt_o;

      if (kind == 1) begin
         put_bit(0); put_bit(0); put_bit(1); put_bit(1);
         put_bit(0); put_bit(0); put_bit(1); put_bit(1);
      end else if (kind == 2) begin
         for (int i = 0; i < 16; i++) put_bit(1'(~i[0]));
         put_bit(0);
      end
      for (int i = 0; i < 31; i++) begin
         put_bit(1); put_bit(0);
      end
      put_bit(1); put_bit(1);
      for (int i = 0; i < nbits; i++) put_bit(tx[i]);
      @(negedge clk);
      crs_i = 1'b0;
      rx_bit_vld_i = 1'b0;
      repeat (4) @(negedge clk);

      if (kind == 2) begin
         check(ncap == 0, "R2", "bytes from dropped frame", ncap, 0);
         check(neof == 0, "R2", "status from dropped frame", neof, 0);
         check(runt_cnt_o == runt_before, "R2", "runt count after drop", runt_cnt_o, runt_before);
      end else begin
         bad = 0; bad_da = 0; bad_last = 0;
         for (int i = 0; i < ncap && i < nfull; i++) begin
            for (int k = 0; k < 8; k++) eb[k] = tx[i * 8 + k];
            if (cap_b[i] !== eb) bad++;
            if (cap_da[i] !== (i < 6)) bad_da++;
            if (cap_last[i] !== (i == nfull - 1)) bad_last++;
         end
         check(ncap == nfull, "R5", "byte count", ncap, nfull);
         check(bad == 0, corrupt ? "R8" : "R3", "mismatching bytes", bad, 0);
         check(bad_da == 0, "R4", "address flag errors", bad_da, 0);
         check(bad_last == 0, "R3", "last flag errors", bad_last, 0);
         check(neof == 1, "R10", "end status pulses", neof, 1);
         check(got_fcs == exp_fcs, "R6", "fcs error flag", got_fcs, exp_fcs);
         check(got_fram == (exp_fcs && drib != 0), "R7", "framing error flag",
               got_fram, exp_fcs && drib != 0);
         check(runt_cnt_o == 16'(runt_before + (nfull < 64)), "R9", "runt count",
               runt_cnt_o, runt_before + (nfull < 64));
      end
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!byte_vld_o && !eof_vld_o && !eof_fcs_err_o && !eof_fram_err_o && runt_cnt_o == 0,
            "R10", "reset state", {byte_vld_o, eof_vld_o, runt_cnt_o}, 0);

      run_frame(60, 0, 1'b0, 0);   // exactly 64 bytes, good, not runt (R9)
      run_frame(20, 3, 1'b0, 0);   // good CRC, 3 leftover bits: no framing error (R7)
      run_frame(30, 0, 1'b1, 0);   // bad CRC, zero leftover: framing 0 (R7)
      run_frame(30, 5, 1'b1, 0);   // bad CRC, leftover: framing 1 (R7)
      run_frame(46, 8, 1'b0, 0);   // eight extra bits become a byte (R5)
      run_frame(40, 7, 1'b0, 1);   // pairs in ignored window (R1)
      run_frame(25, 2, 1'b0, 2);   // 0-0 pair beyond window (R2)
      run_frame(12, 0, 1'b0, 0);   // search restarts after drop (R2)
      run_frame(0, 1, 1'b0, 0);    // FCS only (R4)

      for (int i = 0; i < 14; i++)
         run_frame(int'($urandom % 70), int'($urandom % 9), 1'($urandom), 0);

      @(negedge clk);
      runt_clr_i = 1'b1;
      @(negedge clk);
      runt_clr_i = 1'b0;
      check(runt_cnt_o == 0, "R9", "runt count after clear", runt_cnt_o, 0);

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (190000) @(posedge clk);
            n_tests++;
            n_fail++;
            $display("FAIL R10 watchdog expired: actual 1 expected 0");
         end
      join_any
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule